// File: doc/BRIEF.md
# Strapped-Address I2C Configuration Register Bank

This block is a two-wire serial slave that holds a bank of 24 byte-wide configuration registers and presents all of them at once on a flat parallel bus for the surrounding logic. The bus clock and data lines arrive as plain inputs. The block pulls the data line low by raising a single output-enable pin. The pad and the pull-up are outside the block. Both bus lines pass through a two-flop synchroniser. START and STOP are recognised as data-line edges that occur while the clock line is high.

The 7-bit device address has a fixed upper part, binary 11011. Its two low bits come from strap pins, so up to four banks can share one bus. A write transfer names a register pointer and then streams bytes into consecutive registers. A read transfer first sets the pointer with a short write phase. It then issues a repeated START with the read bit and streams bytes out from that pointer. The master acknowledges each byte it wants continued and does not acknowledge the last one.

The bus is the only data path. The block has no valid/ready stream edge and does not stretch the clock. The master sets the pace, and the core clock must run fast enough to see every bus phase after synchronisation.

Top module: `i2c_cfg_regbank`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal 1,1,0,1,1,sel[1],sel[0], with bit 0 as the read flag (1 = read). Any other address receives no acknowledge. The block then leaves the bus alone until the next START, and bytes clocked in that time change no register.
- R2: In a write transfer the first byte after the address sets the register pointer. Each following byte goes MSB first into the register at the pointer, is acknowledged, and moves the pointer up by one. Register k appears on `reg_image[8k+7:8k]`.
- R3: After a write phase that sets pointer P, a repeated START with the read flag returns bytes MSB first from register P upward. The pointer steps by one per byte.
- R4: During a read the slave sends another byte when the master acknowledges. After a not-acknowledge the slave releases the data line and sends nothing more until a new START.
- R5: A STOP after any complete byte ends the transfer. Bytes already acknowledged stay written, and no other register changes.
- R6: Write bytes aimed at positions above 23 are acknowledged but dropped. Read bytes from positions above 23 return 0x00.
- R7: After reset, register 0 holds 0x03, with its two output-enable bits set. Every other register holds 0x00, and the data line is released.
- R8: The block changes its data-line drive only while the synchronised clock line is low, or when it releases the line on a START or STOP.
- R9: The register image changes only in the cycle after an acknowledged, in-range write byte. Reads and traffic meant for other devices leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Strap pins for the two low device-address bits |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_image | output | 192 | All 24 registers, register k at bits 8k+7:8k |

## Verification
The bench writes a block that starts mid-bank and reads it back across the untouched register in front of it. A design with a wrong pointer step or bit order would return shifted or bit-reversed bytes. It sends a foreign address followed by data bytes. A block that decodes the strap bits wrongly would acknowledge, or would write registers, while it should be ignoring the bus. It runs a write and a read that cross byte 23: wrap-around or missing bounds would corrupt register 0 or return stale data instead of 0x00. It also stops after a single data byte and watches every change of the data-line drive. A drive change while the clock line is high would be taken as a false START or STOP.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } i2c_state_e;

  // Reset value of each register: byte 0 carries the two output-enable bits.
  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 0) ? 8'h03 : 8'h00;
  endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else if (g == 0) begin
          scl_q[g] <= scl_i;
          sda_q[g] <= sda_i;
        end else begin
          scl_q[g] <= scl_q[(g == 0) ? 0 : g-1];
          sda_q[g] <= sda_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int PTR_W    = 8,
  localparam int IMG_W   = NUM_REGS * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic [IMG_W-1:0] image
);
  logic [7:0] regs [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[g] <= reg_default(g);
        else if (we && waddr == PTR_W'(g))
          regs[g] <= wdata;
      end
      assign image[8*g +: 8] = regs[g];
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == PTR_W'(i)) rd_data = regs[i];
  end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_cfg_pkg::*;
#(
  parameter int              NUM_REGS = 24,
  parameter int              PTR_W    = 8,
  parameter int              SEL_W    = 2,
  parameter logic [6-SEL_W:0] DEV_HI  = 5'b11011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_s,
  input  logic [SEL_W-1:0] addr_sel,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr,
  output logic             we,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wdata,
  output logic             sda_oe,
  output i2c_state_e       state,
  output logic [7:0]       rx_byte
);
  localparam logic [PTR_W-1:0] REG_END = PTR_W'(NUM_REGS);
  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  logic [3:0] bitcnt;
  logic [7:0] tx;
  logic       rw;
  logic       more;

  assign rx_byte = rx_q;
  logic [7:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      rx_q    <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      more    <= 1'b0;
      ptr     <= '0;
      we      <= 1'b0;
      wr_addr <= '0;
      wdata   <= '0;
      sda_oe  <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_PTR, ST_WR: begin
            if (scl_rise) begin
              rx_q   <= {rx_q[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == ST_DEV) begin
                if (rx_q[7:1] == {DEV_HI, addr_sel}) begin
                  rw     <= rx_q[0];
                  sda_oe <= 1'b1;
                  state  <= ST_DEV_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                ptr    <= rx_q;
                sda_oe <= 1'b1;
                state  <= ST_PTR_ACK;
              end else begin
                we      <= (ptr < REG_END);
                wr_addr <= ptr;
                wdata   <= rx_q;
                if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                sda_oe  <= 1'b1;
                state   <= ST_WR_ACK;
              end
            end
          end
          ST_DEV_ACK, ST_PTR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (state == ST_DEV_ACK && rw) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                state  <= ST_RD;
              end else if (state == ST_DEV_ACK) begin
                state <= ST_PTR;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              more <= ~sda_s;
            end else if (scl_fall) begin
              if (more) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
                state  <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_cfg_regbank.sv
module i2c_cfg_regbank
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 24,
  parameter int PTR_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IMG_W      = NUM_REGS * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       addr_sel,
  output logic             sda_oe,
  output logic [IMG_W-1:0] reg_image
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] ptr, wr_addr;
  logic [7:0] rd_data, wdata, rx_byte;
  logic we;
  i2c_state_e state;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_fsm #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .SEL_W(2), .DEV_HI(5'b11011)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .addr_sel(addr_sel), .rd_data(rd_data), .ptr(ptr), .we(we),
    .wr_addr(wr_addr), .wdata(wdata), .sda_oe(sda_oe), .state(state),
    .rx_byte(rx_byte)
  );

  i2c_reg_file #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(wr_addr), .wdata(wdata),
    .rd_addr(ptr), .rd_data(rd_data), .image(reg_image)
  );

endmodule

// File: rtl/i2c_cfg_regbank_chk.sv
module i2c_cfg_regbank_chk
  import i2c_cfg_pkg::*;
#(
  parameter int IMG_W = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             we,
  input logic [1:0]       addr_sel,
  input logic [7:0]       rx_byte,
  input i2c_state_e       state,
  input logic [IMG_W-1:0] reg_image
);
  AST_ACK_ONLY_OWN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && state == ST_DEV_ACK) |-> (rx_byte[7:1] == {5'b11011, addr_sel})); // R1

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R4

  AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))); // R8

  AST_IMAGE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(reg_image)); // R9
endmodule

bind i2c_cfg_regbank i2c_cfg_regbank_chk #(.IMG_W(IMG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .we(we),
  .addr_sel(addr_sel), .rx_byte(rx_byte), .state(state),
  .reg_image(reg_image)
);

// File: tb/i2c_cfg_regbank_test.sv
module i2c_cfg_regbank_test;
  localparam int NREG = 24;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b10;
  logic sda_oe;
  logic [NREG*8-1:0] reg_image;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_rd = 1'b0;
  int drive_viol = 0;

  logic [7:0] model [NREG];
  logic [7:0] exp_q [$];
  logic [7:0] cur_rx;
  int nbits = 0;
  logic ack;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_regbank uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .reg_image(reg_image)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic got_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    end
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    got_ack = ~sda_line;
    qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic recv_byte(input bit give_ack);
    mon_rd = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    end
    mon_rd = 1'b0;
    sda_m = give_ack ? 1'b0 : 1'b1; qwait(); scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait(); sda_m = 1'b1;
  endtask

  task automatic check_image(input string tag);
    for (int k = 0; k < NREG; k++)
      check(reg_image[8*k +: 8] == model[k], tag, reg_image[8*k +: 8], model[k]);
  endtask

  // Driver: block write; model updated from R2/R6 rules.
  task automatic write_block(input logic [7:0] p, input logic [7:0] d [], input string tag);
    int ptr;
    bus_start();
    send_byte({5'b11011, addr_sel, 1'b0}, ack);
    check(ack, {tag, " R1 address ack"}, ack, 1);
    send_byte(p, ack);
    check(ack, {tag, " R2 pointer ack"}, ack, 1);
    ptr = p;
    foreach (d[i]) begin
      send_byte(d[i], ack);
      check(ack, {tag, " R2/R6 data ack"}, ack, 1);
      if (ptr < NREG) model[ptr] = d[i];
      ptr++;
    end
    bus_stop();
    qwait();
  endtask

  // Driver: block read; expected bytes pushed for the monitor (R3, R6).
  task automatic read_block(input logic [7:0] p, input int n, input string tag);
    bus_start();
    send_byte({5'b11011, addr_sel, 1'b0}, ack);
    check(ack, {tag, " R3 address ack"}, ack, 1);
    send_byte(p, ack);
    check(ack, {tag, " R3 pointer ack"}, ack, 1);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    send_byte({5'b11011, addr_sel, 1'b1}, ack);
    check(ack, {tag, " R3 read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back((p + i < NREG) ? model[p + i] : 8'h00);
      recv_byte(i < n - 1);
    end
    check(sda_oe == 1'b0, {tag, " R4 release after NACK"}, sda_oe, 0);
    bus_stop();
    qwait();
    check(exp_q.size() == 0, {tag, " R3 all bytes seen"}, exp_q.size(), 0);
  endtask

  // Monitor: assemble bytes the slave sends and compare with the scoreboard.
  initial begin
    forever begin
      @(posedge scl_m);
      if (mon_rd) begin
        cur_rx = {cur_rx[6:0], sda_line};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          if (exp_q.size() == 0) check(1'b0, "R3 unexpected read byte", cur_rx, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(cur_rx == e, "R3/R6 read data", cur_rx, e);
          end
        end
      end
    end
  end

  // R8: the slave must not move its drive while the bus clock is high.
  always @(sda_oe) if (rst_n && scl_m) drive_viol++;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d3 [] = '{8'hA5, 8'h3C, 8'h7E};
    logic [7:0] d4 [] = '{8'h11, 8'h22, 8'h33, 8'h44};
    logic [7:0] d1 [] = '{8'h5A};
    for (int k = 0; k < NREG; k++) model[k] = (k == 0) ? 8'h03 : 8'h00;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R7 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_image("R7 defaults");

    write_block(8'd2, d3, "mid-bank");
    check_image("R2 after write");
    read_block(8'd1, 4, "mid-bank");
    check_image("R9 unchanged by read");

    // R1: foreign address (strap bits 00) followed by data bytes.
    bus_start();
    send_byte({5'b11011, 2'b00, 1'b0}, ack);
    check(!ack, "R1 foreign address no ack", ack, 0);
    send_byte(8'h05, ack);
    check(!ack, "R1 ignored byte no ack", ack, 0);
    send_byte(8'hFF, ack);
    check(!ack, "R1 ignored byte no ack", ack, 0);
    bus_stop();
    qwait();
    check_image("R1 R9 image untouched");

    write_block(8'd22, d4, "top-edge");
    check_image("R6 discard above 23");
    read_block(8'd22, 4, "top-edge");

    write_block(8'd0, d1, "short");
    check_image("R5 stop after one byte");
    read_block(8'd0, 2, "short");

    addr_sel = 2'b01;
    qwait();
    read_block(8'd3, 2, "strap-01");

    check(drive_viol == 0, "R8 drive change with SCL high", drive_viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule